// File: doc/BRIEF.md
# Block-mode DMA channel engine

This block is one DMA channel that copies a run of 32-bit words between system RAM and a peripheral data port. Software (or a neighbouring controller) writes three registers: a byte start address, a size word whose two 16-bit halves are multiplied to give the word count, and a control word that picks the direction and starts the run. The engine then walks RAM upward one word at a time. It drives a synchronous single-port RAM with a one-cycle read latency on one side and a valid/ready stream on the other.

When the run finishes, the address register holds the byte address just past the last word moved. The start bit in the control register drops and a one-cycle interrupt request is raised. If a run would pass the end of RAM, it is cut short at the last valid word. A control value that names no supported direction starts nothing, but it is still acknowledged with the interrupt.

Top module: `dma_blk_chan`

## Requirements
- R1: After reset the address, size and control registers read 0, busy and irq are low, and neither the RAM port nor the peripheral port is active.
- R2: The requested length in words is the size register's bits 31:16 multiplied by its bits 15:0. A product of zero moves nothing.
- R3: Writing control value 0x01000201 (register select 2) with the channel idle reads RAM words in ascending address order and presents them in that order on the outgoing stream.
- R4: Writing control value 0x01000200 writes each word accepted from the incoming stream to RAM in ascending address order.
- R5: Address bits 1:0 are treated as zero when the run's start word is formed.
- R6: At completion the address register (select 0) equals the aligned start address plus four times the number of words moved.
- R7: At completion, control bit 24 reads 0 and irq is high for exactly one cycle. That cycle is the one after the last word beat, and busy falls in the same cycle.
- R8: Words that would lie at or beyond the RAM size are not moved. A run starting past the end moves zero words. Incoming words beyond the clamped count are not accepted.
- R9: A control write with bit 24 set and any value other than the two in R3 and R4 moves no data. It is stored with bit 24 cleared, and irq pulses in the next cycle.
- R10: A control write with bit 24 clear is stored as written and causes neither a transfer nor an interrupt.
- R11: Busy is high from the cycle after a starting write until the irq cycle. With the far side always ready, a peripheral-to-RAM run of N words holds busy for N cycles and a RAM-to-peripheral run for N+2 cycles.
- R12: Register writes are ignored while busy is high.
- R13: A valid direction with a clamped length of zero does not raise busy. It pulses irq in the next cycle and loads the aligned start address into the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 size, 2 control |
| cfg_wdata | input | 32 | Register write data |
| addr_q | output | 32 | Address register contents |
| blk_q | output | 32 | Size register contents |
| ctl_q | output | 32 | Control register contents |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM word index |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after ram_en |
| pout_valid | output | 1 | Outgoing word valid |
| pout_ready | input | 1 | Peripheral accepts outgoing word |
| pout_data | output | 32 | Outgoing word |
| pin_valid | input | 1 | Incoming word valid |
| pin_ready | output | 1 | Engine accepts incoming word |
| pin_data | input | 32 | Incoming word |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Both directions are swept over start addresses that are aligned, unaligned, close to the end of RAM and past it. The size pairs include zero factors, single words, products larger than RAM, and sizes whose two halves would give a different count if added rather than multiplied. Each run is repeated with the far side always ready, alternating, and pseudo-random. The always-ready pattern pins down the exact busy length, which shows whether the read pipeline sustains one word per cycle. The stalling patterns show whether words are lost or duplicated under back-pressure. Unsupported control values, control writes without the start bit, and a register write issued mid-run confirm that nothing moves or changes.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_M2P  = 2'd1,
    DIR_P2M  = 2'd2
  } dir_e;

  localparam logic [31:0] CTL_M2P    = 32'h0100_0201;
  localparam logic [31:0] CTL_P2M    = 32'h0100_0200;
  localparam int          START_BIT  = 24;
  localparam logic [31:0] START_MASK = 32'h0100_0000;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_BLK  = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;

  // requested word count: high half times low half
  function automatic logic [31:0] blk_words(input logic [31:0] blk);
    return {16'h0, blk[31:16]} * {16'h0, blk[15:0]};
  endfunction

  function automatic logic [31:0] align_addr(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction

  // words that fit between the start word and the end of RAM
  function automatic logic [31:0] clamp_words(input logic [31:0] want,
                                              input logic [31:0] start_word,
                                              input logic [31:0] ram_words);
    logic [31:0] avail;
    avail = (start_word >= ram_words) ? 32'h0 : (ram_words - start_word);
    return (want < avail) ? want : avail;
  endfunction

  function automatic logic [31:0] end_addr_of(input logic [31:0] aligned,
                                              input logic [31:0] moved);
    return aligned + {moved[29:0], 2'b00};
  endfunction

endpackage

// File: rtl/dma_blk_decode.sv
module dma_blk_decode
  import dma_blk_pkg::*;
#(
  parameter int RAM_WORDS = 256,
  parameter int AW        = 8,
  parameter int CW        = 9
) (
  input  logic [31:0]   ctl_val,
  input  logic [31:0]   addr_val,
  input  logic [31:0]   blk_val,
  output dir_e          dir,
  output logic          go,
  output logic [CW-1:0] copy_words,
  output logic [AW-1:0] start_ptr,
  output logic [31:0]   end_addr
);
  logic [31:0] aligned;
  logic [31:0] start_word;
  logic [31:0] want;
  logic [31:0] copy32;

  always_comb begin
    aligned    = align_addr(addr_val);
    start_word = {2'b00, aligned[31:2]};
    want       = blk_words(blk_val);
    copy32     = clamp_words(want, start_word, 32'(RAM_WORDS));
    copy_words = copy32[CW-1:0];
    start_ptr  = start_word[AW-1:0];
    end_addr   = end_addr_of(aligned, copy32);
    go         = ctl_val[START_BIT];
    if (ctl_val == CTL_M2P)      dir = DIR_M2P;
    else if (ctl_val == CTL_P2M) dir = DIR_P2M;
    else                         dir = DIR_NONE;
  end

endmodule

// File: rtl/dma_blk_fifo.sv
module dma_blk_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [NW-1:0] level
);
  logic [DW-1:0] slots [DEPTH];
  logic [PW-1:0] wptr, rptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      if (push && !pop)      level <= level + NW'(1);
      else if (pop && !push) level <= level - NW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wptr] <= push_data;
  end

  assign out_valid = (level != '0);
  assign out_data  = slots[rptr];

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |-> level < NW'(DEPTH)); // R3
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> out_valid); // R3

endmodule

// File: rtl/dma_blk_chan.sv
module dma_blk_chan
  import dma_blk_pkg::*;
#(
  parameter int RAM_WORDS = 256,
  localparam int AW = (RAM_WORDS > 1) ? $clog2(RAM_WORDS) : 1,
  localparam int CW = $clog2(RAM_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   addr_q,
  output logic [31:0]   blk_q,
  output logic [31:0]   ctl_q,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [31:0]   ram_wdata,
  input  logic [31:0]   ram_rdata,
  output logic          pout_valid,
  input  logic          pout_ready,
  output logic [31:0]   pout_data,
  input  logic          pin_valid,
  output logic          pin_ready,
  input  logic [31:0]   pin_data,
  output logic          busy,
  output logic          irq
);
  localparam int FD  = 2;
  localparam int FNW = $clog2(FD + 1);

  // registers
  logic [31:0]   addr_r, blk_r, ctl_r;
  logic          busy_r, irq_r, rd_vld_r;
  dir_e          dir_r;
  logic [CW-1:0] issue_left, beat_left;
  logic [AW-1:0] ptr;
  logic [31:0]   end_r;

  // decode results
  dir_e          dec_dir;
  logic          dec_go;
  logic [CW-1:0] dec_copy;
  logic [AW-1:0] dec_ptr;
  logic [31:0]   dec_end;

  // named events
  logic ev_wr_ok, ev_start, ev_launch, ev_zero, ev_issue, ev_pop;
  logic ev_wbeat, ev_beat, ev_last, ev_done;

  logic [FNW-1:0] fifo_level;
  logic [2:0]     occ_next;

  dma_blk_decode #(.RAM_WORDS(RAM_WORDS), .AW(AW), .CW(CW)) u_dec (
    .ctl_val    (cfg_wdata),
    .addr_val   (addr_r),
    .blk_val    (blk_r),
    .dir        (dec_dir),
    .go         (dec_go),
    .copy_words (dec_copy),
    .start_ptr  (dec_ptr),
    .end_addr   (dec_end)
  );

  dma_blk_fifo #(.DW(32), .DEPTH(FD)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rd_vld_r),
    .push_data (ram_rdata),
    .pop       (ev_pop),
    .out_valid (pout_valid),
    .out_data  (pout_data),
    .level     (fifo_level)
  );

  always_comb begin
    ev_wr_ok  = cfg_we && !busy_r;
    ev_start  = ev_wr_ok && (cfg_sel == SEL_CTL) && dec_go;
    ev_launch = ev_start && (dec_dir != DIR_NONE) && (dec_copy != '0);
    ev_zero   = ev_start && (dec_dir != DIR_NONE) && (dec_copy == '0);
    ev_pop    = pout_valid && pout_ready;
    occ_next  = 3'(fifo_level) + {2'b00, rd_vld_r} - {2'b00, ev_pop};
    ev_issue  = busy_r && (dir_r == DIR_M2P) && (issue_left != '0)
                && (occ_next < 3'(FD));
    ev_wbeat  = busy_r && (dir_r == DIR_P2M) && pin_valid;
    ev_beat   = (dir_r == DIR_M2P) ? ev_pop : ev_wbeat;
    ev_last   = busy_r && ev_beat && (beat_left == CW'(1));
    ev_done   = (ev_start && !ev_launch) || ev_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_r     <= '0;
      blk_r      <= '0;
      ctl_r      <= '0;
      busy_r     <= 1'b0;
      irq_r      <= 1'b0;
      rd_vld_r   <= 1'b0;
      dir_r      <= DIR_NONE;
      issue_left <= '0;
      beat_left  <= '0;
      ptr        <= '0;
      end_r      <= '0;
    end else begin
      irq_r    <= ev_done;
      rd_vld_r <= ev_issue;
      if (ev_wr_ok) begin
        case (cfg_sel)
          SEL_ADDR: addr_r <= cfg_wdata;
          SEL_BLK:  blk_r  <= cfg_wdata;
          SEL_CTL:  ctl_r  <= ev_launch ? cfg_wdata : (cfg_wdata & ~START_MASK);
          default:  ;
        endcase
      end
      if (ev_zero) addr_r <= dec_end;
      if (ev_launch) begin
        busy_r     <= 1'b1;
        dir_r      <= dec_dir;
        issue_left <= dec_copy;
        beat_left  <= dec_copy;
        ptr        <= dec_ptr;
        end_r      <= dec_end;
      end
      if (busy_r) begin
        if (ev_issue)             issue_left <= issue_left - CW'(1);
        if (ev_issue || ev_wbeat) ptr        <= ptr + AW'(1);
        if (ev_beat)              beat_left  <= beat_left - CW'(1);
        if (ev_last) begin
          busy_r           <= 1'b0;
          addr_r           <= end_r;
          ctl_r[START_BIT] <= 1'b0;
        end
      end
    end
  end

  assign addr_q    = addr_r;
  assign blk_q     = blk_r;
  assign ctl_q     = ctl_r;
  assign busy      = busy_r;
  assign irq       = irq_r;
  assign pin_ready = busy_r && (dir_r == DIR_P2M);
  assign ram_en    = ev_issue || ev_wbeat;
  assign ram_we    = ev_wbeat;
  assign ram_addr  = ptr;
  assign ram_wdata = pin_data;

  AST_BUSY_FALL_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq); // R7
  AST_IRQ_START_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !ctl_q[START_BIT]); // R7
  AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy); // R11
  AST_BUSY_RISE_START_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ctl_q[START_BIT]); // R11
  AST_RAM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> 32'(ram_addr) < 32'(RAM_WORDS)); // R8
  AST_NO_WRITE_OUTBOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> pin_ready); // R4
  AST_NO_OUTBOUND_WHEN_INBOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ready |-> !pout_valid); // R3
  AST_ADDR_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(addr_q) && $stable(blk_q)); // R12

endmodule

// File: tb/dma_blk_chan_bench.sv
module dma_blk_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RAMW = 64;
  localparam int AW = 6;
  localparam logic [31:0] M2P = 32'h0100_0201;
  localparam logic [31:0] P2M = 32'h0100_0200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] addr_q, blk_q, ctl_q, ram_wdata, pout_data;
  logic [31:0] ram_rdata = '0, pin_data = '0;
  logic ram_en, ram_we, pout_valid, pin_ready, busy, irq;
  logic pout_ready = 1'b0, pin_valid = 1'b0;
  logic [AW-1:0] ram_addr;

  int checks = 0, errors = 0;
  int mode = 0, sink_n = 0, src_idx = 0, ram_act = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] mem [RAMW];
  logic [31:0] got [RAMW];

  dma_blk_chan #(.RAM_WORDS(RAMW)) u_dma_blk_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .addr_q(addr_q), .blk_q(blk_q), .ctl_q(ctl_q),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .pout_valid(pout_valid), .pout_ready(pout_ready),
    .pout_data(pout_data), .pin_valid(pin_valid), .pin_ready(pin_ready),
    .pin_data(pin_data), .busy(busy), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE_0000 | 32'((i * 37) & 16'hFFFF);
  endfunction
  function automatic logic [31:0] src(input int i);
    return 32'h5EED_0000 + 32'(i);
  endfunction

  // RAM model, stream sink and stream source
  always @(posedge clk) begin
    cyc++;
    if (ram_en) begin
      ram_act++;
      if (ram_we) mem[ram_addr] = ram_wdata;
      else ram_rdata <= mem[ram_addr];
    end
    if (pout_valid && pout_ready) begin
      if (sink_n < RAMW) got[sink_n] = pout_data;
      sink_n++;
    end
    if (pin_valid && pin_ready) src_idx++;
  end

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      0: begin pout_ready = 1'b1; pin_valid = 1'b1; end
      1: begin pout_ready = cyc[0]; pin_valid = ~cyc[0]; end
      default: begin pout_ready = lfsr[0]; pin_valid = lfsr[3]; end
    endcase
    pin_data = src(src_idx);
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_case(input logic [31:0] ctl, input logic [31:0] a,
                          input logic [15:0] bs, input logic [15:0] ba,
                          input int m, input bit poke);
    int sw, want, avail, cp, bcy, icy, bad, k;
    logic [31:0] al;
    bit isdir, done;
    mode = m;
    for (int i = 0; i < RAMW; i++) mem[i] = pat(i);
    sink_n = 0; src_idx = 0;
    cfg_write(2'd0, a);
    cfg_write(2'd1, {bs, ba});
    ram_act = 0;
    cfg_write(2'd2, ctl);
    al = a & ~32'h3; sw = int'(al >> 2);
    want = int'(bs) * int'(ba);
    avail = (sw >= RAMW) ? 0 : RAMW - sw;
    cp = (want < avail) ? want : avail;
    isdir = (ctl == M2P) || (ctl == P2M);
    if (!isdir) cp = 0;
    bcy = 0; icy = 0; done = 0;
    for (k = 0; k < 4000; k++) begin
      if (busy) bcy++;
      if (irq) icy++;
      if (poke && k == 2) begin cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h40; end
      if (poke && k == 3) begin
        cfg_we = 1'b0;
        check(addr_q == a, "R12", "addr written while busy", addr_q, a);
      end
      if (!busy && icy > 0 && k >= 3) begin done = 1; break; end
      @(negedge clk);
    end
    check(done, "R11", "run finished", 32'(k), 32'(cp));
    for (int j = 0; j < 3; j++) begin @(negedge clk); if (irq) icy++; end
    check(icy == 1, "R7", "irq pulse count", 32'(icy), 32'd1);
    check(ctl_q == (ctl & ~32'h0100_0000), "R7", "control after completion", ctl_q,
          ctl & ~32'h0100_0000);
    if (isdir) begin
      check(addr_q == al + 32'(cp * 4), (cp == 0) ? "R13" : "R6", "end address",
            addr_q, al + 32'(cp * 4));
      if (m == 0)
        check(bcy == ((cp == 0) ? 0 : ((ctl == M2P) ? cp + 2 : cp)), "R11", "busy cycles",
              32'(bcy), 32'((cp == 0) ? 0 : ((ctl == M2P) ? cp + 2 : cp)));
    end else begin
      check(ram_act == 0 && sink_n == 0 && src_idx == 0 && addr_q == a, "R9",
            "activity on ignored control", 32'(ram_act + sink_n + src_idx), 32'd0);
    end
    if (ctl == M2P) begin
      check(sink_n == cp, (cp < want) ? "R8" : "R2", "outgoing word count",
            32'(sink_n), 32'(cp));
      bad = 0;
      for (int i = 0; i < cp; i++) if (got[i] !== pat(sw + i)) bad++;
      check(bad == 0, (a[1:0] != 2'b00) ? "R5" : "R3", "outgoing data mismatches",
            32'(bad), 32'd0);
    end
    if (ctl == P2M) begin
      check(src_idx == cp, (cp < want) ? "R8" : "R2", "incoming word count",
            32'(src_idx), 32'(cp));
      bad = 0;
      for (int i = 0; i < cp; i++) if (mem[sw + i] !== src(i)) bad++;
      if (sw + cp < RAMW && mem[sw + cp] !== pat(sw + cp)) bad++;
      check(bad == 0, (a[1:0] != 2'b00) ? "R5" : "R4", "RAM contents mismatches",
            32'(bad), 32'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int addrs [8] = '{0, 5, 32'h7E, 32'hF8, 32'hFC, 32'h100, 32'h400, 32'h23};
  int sizes [7][2] = '{'{1, 1}, '{3, 2}, '{0, 5}, '{5, 0}, '{4, 16}, '{2, 1}, '{256, 256}};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(addr_q == 0 && blk_q == 0 && ctl_q == 0, "R1", "registers after reset",
          addr_q | blk_q | ctl_q, 32'd0);
    check(!busy && !irq && !ram_en && !pout_valid && !pin_ready, "R1", "outputs after reset",
          {27'd0, busy, irq, ram_en, pout_valid, pin_ready}, 32'd0);

    // R10 control without start bit
    begin
      int ic = 0;
      cfg_write(2'd2, 32'h0000_0201);
      for (int j = 0; j < 4; j++) begin if (irq || busy) ic++; @(negedge clk); end
      check(ic == 0, "R10", "irq/busy after write without start", 32'(ic), 32'd0);
      check(ctl_q == 32'h0000_0201, "R10", "stored control", ctl_q, 32'h0000_0201);
    end

    // R9 unsupported control values
    run_case(32'h0100_0205, 32'h10, 16'd2, 16'd2, 0, 1'b0);
    run_case(32'h0100_0001, 32'h10, 16'd2, 16'd2, 0, 1'b0);
    run_case(32'h1100_0002, 32'h10, 16'd2, 16'd2, 0, 1'b0);

    // R12 write during a long run
    run_case(P2M, 32'h0, 16'd8, 16'd4, 1, 1'b1);
    run_case(M2P, 32'h0, 16'd8, 16'd4, 1, 1'b1);

    // sweep
    for (int d = 0; d < 2; d++)
      for (int ai = 0; ai < 8; ai++)
        for (int si = 0; si < 7; si++)
          for (int m = 0; m < 3; m++)
            run_case(d == 0 ? M2P : P2M, 32'(addrs[ai]), 16'(sizes[si][0]),
                     16'(sizes[si][1]), m, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule